// File: doc/BRIEF.md
# Page-Capable Asynchronous DRAM Controller

This block sits between a 16-bit processor bus and a bank of asynchronous DRAM. It turns one processor access into a timed sequence of row strobe, column strobe and write-enable edges, with a multiplexed row/column address. The processor side gives an active-low address strobe, two active-low byte strobes, a read/write level, a lock level for indivisible read-modify-write, and a wait-state select. The controller answers with an active-low data acknowledge.

The block runs on one clock. A phase bit toggles on every clock. The first clock edge after reset release opens a *falling* phase (odd cycle count), and the next edge opens a *rising* phase (even count). Every strobe edge is placed on a phase of a given polarity. Plain reads and writes use one RAS pulse and one CAS pulse. A locked read keeps RAS low and pulses CAS a second time for the write half. That second CAS is released by the byte strobes rather than by the clock. CAS-before-RAS refresh cycles come from an internal interval counter. They are started only when the bus is idle.

Top module: `dram_ctrl`

## Requirements
- R1: While reset is asserted, ras_n, cas_n, we_n and dtack_n are high and dram_a is zero. Once reset is released and the bus is idle, dram_a presents the row half addr[2*COL_W-1:COL_W] one clock after addr is applied.
- R2: With wait_one low, an access asserts RAS on a rising phase (even count) and CAS one phase later.
- R3: With wait_one high, an access asserts RAS on a falling phase (odd count) and CAS three phases later.
- R4: In the first RAS-asserted cycle, dram_a still shows the row half. In the cycle CAS asserts, dram_a shows the column half addr[COL_W-1:0].
- R5: dtack_n goes low 2 phases after CAS asserts with wait_one low, and 4 phases after with wait_one high. This holds for both halves of a locked cycle.
- R6: After as_n is sampled high, RAS and CAS are released in the same cycle, on a falling phase. dtack_n is released in that cycle too.
- R7: For writes (rw low), we_n is low no later than the cycle before CAS asserts. For reads, we_n stays high.
- R8: In a locked cycle, RAS stays low throughout. CAS goes high one clock after both byte strobes are sampled high. CAS stays high while the strobes stay high. CAS goes low one clock after a byte strobe is sampled low once rw low has already lowered we_n.
- R9: A refresh asserts CAS on a falling phase while RAS is high. It asserts RAS on the next phase and holds RAS low for REF_HOLD phases (3 by default). It then releases both on a falling phase. we_n stays high throughout.
- R10: Refresh is requested every REF_PERIOD clocks. With an idle bus and an even REF_PERIOD (128 by default), consecutive refresh CAS assertions are exactly REF_PERIOD clocks apart.
- R11: An access requested during a refresh waits until the refresh ends and then completes normally. A pending refresh never interrupts an access that is still holding as_n low; it runs after that access is released.
- R12: Between any two cycles, RAS and CAS are both high for at least PRE_PH+1 clocks (6 by default).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; one period is one phase |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| as_n | input | 1 | Processor address strobe, active low |
| uds_n | input | 1 | Upper byte strobe, active low |
| lds_n | input | 1 | Lower byte strobe, active low |
| rw | input | 1 | 1 = read, 0 = write |
| lock | input | 1 | Marks a read-modify-write access, sampled at start |
| wait_one | input | 1 | 1 selects one wait state, sampled at start |
| addr | input | 2*COL_W | Word address: upper half row, lower half column |
| dtack_n | output | 1 | Data acknowledge to processor, active low |
| dram_a | output | COL_W | Multiplexed DRAM address |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | DRAM write enable, active low |

## Verification
The hardest situation to reach from the ports is a processor write that arrives while a refresh is already under way. To reach it, the stimulus idles until it sees CAS fall with RAS still high, and it lowers the address strobe on that same clock. It then watches that we_n and dtack_n stay high until both strobes are released, and that the write then completes. The locked case is reached with slow, hand-stepped byte strobes. These show that the second CAS waits on the strobes and not on the clock. The interval is measured between two refreshes taken back to back on an idle bus, so that neither is delayed by an access.

// File: rtl/dramc_pkg.sv
`timescale 1ns/1ps
package dramc_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_ROW, S_RAS, S_CAS, S_HOLD, S_MID, S_PRE, S_RFC, S_RFR, S_RFH
  } seq_st_t;
endpackage

// File: rtl/dramc_refresh_timer.sv
`timescale 1ns/1ps
module dramc_refresh_timer #(
  parameter int REF_PERIOD = 128
) (
  input  logic clk,
  input  logic rst_n,
  input  logic grant,
  output logic pend
);
  localparam int TW = (REF_PERIOD > 2) ? $clog2(REF_PERIOD) : 1;
  localparam logic [TW-1:0] RELOAD = TW'(REF_PERIOD - 1);

  logic [TW-1:0] cnt_q, cnt_d;
  logic          pend_q, pend_d;
  logic          expire;

  assign expire = (cnt_q == '0);

  always_comb begin
    cnt_d  = expire ? RELOAD : cnt_q - 1'b1;
    pend_d = expire | (pend_q & ~grant);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= RELOAD;
      pend_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      pend_q <= pend_d;
    end
  end

  assign pend = pend_q;

  // R10: a request is kept until the sequencer takes it
  p_pend_kept_r10: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q && !grant |=> pend_q);
  // R10: expiry always raises the request
  p_expiry_sets_r10: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> pend_q);
endmodule

// File: rtl/dramc_addr_mux.sv
`timescale 1ns/1ps
module dramc_addr_mux #(
  parameter int COL_W = 9
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [2*COL_W-1:0] addr,
  input  logic               row_sel,
  output logic [COL_W-1:0]   dram_a
);
  logic [COL_W-1:0] a_d, a_q;

  always_comb a_d = row_sel ? addr[2*COL_W-1:COL_W] : addr[COL_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) a_q <= '0;
    else        a_q <= a_d;
  end

  assign dram_a = a_q;
endmodule

// File: rtl/dramc_seq.sv
`timescale 1ns/1ps
module dramc_seq
  import dramc_pkg::*;
#(
  parameter int PRE_PH   = 5,
  parameter int REF_HOLD = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic as_n,
  input  logic uds_n,
  input  logic lds_n,
  input  logic rw,
  input  logic lock,
  input  logic wait_one,
  input  logic ref_pend,
  output logic ref_grant,
  output logic row_sel,
  output logic ras_n,
  output logic cas_n,
  output logic we_n,
  output logic dtack_n
);
  localparam int CW = $clog2(PRE_PH + REF_HOLD + 8);

  seq_st_t       st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          ph_q;
  logic          ws_q, ws_d, rw_q, rw_d, lk_q, lk_d, h2_q, h2_d;
  logic          ras_q, ras_d, cas_q, cas_d, we_q, we_d, ack_q, ack_d;
  logic [CW-1:0] cas_last, ack_last;

  assign cas_last = ws_q ? CW'(2) : CW'(0);
  assign ack_last = ws_q ? CW'(3) : CW'(1);

  always_comb begin
    st_d = st_q;  cnt_d = cnt_q + 1'b1;
    ws_d = ws_q;  rw_d = rw_q;  lk_d = lk_q;  h2_d = h2_q;
    ras_d = ras_q; cas_d = cas_q; we_d = we_q; ack_d = ack_q;
    ref_grant = 1'b0;
    case (st_q)
      S_IDLE: begin
        cnt_d = '0;
        if (!as_n) begin
          st_d = S_ROW; ws_d = wait_one; rw_d = rw; lk_d = lock; h2_d = 1'b0;
        end else if (ref_pend) begin
          st_d = S_RFC; ref_grant = 1'b1;
        end
      end
      S_ROW: if (ph_q != ws_q) begin
        ras_d = 1'b1; we_d = ~rw_q; cnt_d = '0; st_d = S_RAS;
      end
      S_RAS: if (cnt_q == cas_last) begin
        cas_d = 1'b1; cnt_d = '0; st_d = S_CAS;
      end
      S_CAS: if (cnt_q == ack_last) begin
        ack_d = 1'b1; st_d = S_HOLD;
      end
      S_HOLD, S_MID: begin
        if (as_n) begin
          if (!ph_q) begin
            ras_d = 1'b0; cas_d = 1'b0; we_d = 1'b0; ack_d = 1'b0;
            cnt_d = '0; st_d = S_PRE;
          end
        end else if (st_q == S_HOLD) begin
          if (lk_q && !h2_q && uds_n && lds_n) begin
            cas_d = 1'b0; ack_d = 1'b0; st_d = S_MID;
          end
        end else begin
          if (!rw) we_d = 1'b1;
          if (we_q && (!uds_n || !lds_n)) begin
            cas_d = 1'b1; cnt_d = '0; h2_d = 1'b1; st_d = S_CAS;
          end
        end
      end
      S_PRE: if (cnt_q == CW'(PRE_PH - 1)) st_d = S_IDLE;
      S_RFC: if (!ph_q) begin
        cas_d = 1'b1; st_d = S_RFR;
      end
      S_RFR: begin
        ras_d = 1'b1; cnt_d = '0; st_d = S_RFH;
      end
      S_RFH: if (cnt_q >= CW'(REF_HOLD - 1) && !ph_q) begin
        ras_d = 1'b0; cas_d = 1'b0; cnt_d = '0; st_d = S_PRE;
      end
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= S_IDLE; cnt_q <= '0; ph_q <= 1'b0;
      ws_q <= 1'b0; rw_q <= 1'b1; lk_q <= 1'b0; h2_q <= 1'b0;
      ras_q <= 1'b0; cas_q <= 1'b0; we_q <= 1'b0; ack_q <= 1'b0;
    end else begin
      st_q <= st_d; cnt_q <= cnt_d; ph_q <= ~ph_q;
      ws_q <= ws_d; rw_q <= rw_d; lk_q <= lk_d; h2_q <= h2_d;
      ras_q <= ras_d; cas_q <= cas_d; we_q <= we_d; ack_q <= ack_d;
    end
  end

  assign row_sel = !(st_q inside {S_RAS, S_CAS, S_HOLD, S_MID});
  assign ras_n   = ~ras_q;
  assign cas_n   = ~cas_q;
  assign we_n    = ~we_q;
  assign dtack_n = ~ack_q;

  // count of clocks with both strobes high, for the precharge check
  logic [CW-1:0] gap_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 gap_q <= '1;
    else if (!(ras_n && cas_n)) gap_q <= '0;
    else if (gap_q != '1)       gap_q <= gap_q + 1'b1;
  end

  // R2 and R3: access RAS edge lands on the phase chosen by the wait state
  p_ras_phase_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) && cas_n |-> ph_q == ws_q);
  // R5: acknowledge only inside an asserted column strobe
  p_ack_in_cas_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !dtack_n |-> !cas_n && !ras_n);
  // R6: strobes release together on a falling phase
  p_release_pair_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n) |-> cas_n && ph_q);
  // R7: write enable is set up before the column strobe
  p_we_setup_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cas_n) && !we_n |-> $past(!we_n));
  // R9: no write enable while CAS leads RAS
  p_ref_we_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ras_n && !cas_n |-> we_n);
  // R9: refresh CAS starts on a falling phase
  p_ref_cas_phase_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cas_n) && ras_n |-> ph_q);
  // R12: minimum precharge between cycles
  p_precharge_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ras_n && cas_n) && !(ras_n && cas_n) |-> gap_q >= CW'(PRE_PH));
endmodule

// File: rtl/dram_ctrl.sv
`timescale 1ns/1ps
module dram_ctrl #(
  parameter int COL_W      = 9,
  parameter int REF_PERIOD = 128,
  parameter int PRE_PH     = 5,
  parameter int REF_HOLD   = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               as_n,
  input  logic               uds_n,
  input  logic               lds_n,
  input  logic               rw,
  input  logic               lock,
  input  logic               wait_one,
  input  logic [2*COL_W-1:0] addr,
  output logic               dtack_n,
  output logic [COL_W-1:0]   dram_a,
  output logic               ras_n,
  output logic               cas_n,
  output logic               we_n
);
  logic ref_pend, ref_grant, row_sel;

  dramc_refresh_timer #(.REF_PERIOD(REF_PERIOD)) u_timer (
    .clk(clk), .rst_n(rst_n), .grant(ref_grant), .pend(ref_pend)
  );

  dramc_seq #(.PRE_PH(PRE_PH), .REF_HOLD(REF_HOLD)) u_seq (
    .clk(clk), .rst_n(rst_n), .as_n(as_n), .uds_n(uds_n), .lds_n(lds_n),
    .rw(rw), .lock(lock), .wait_one(wait_one), .ref_pend(ref_pend),
    .ref_grant(ref_grant), .row_sel(row_sel), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .dtack_n(dtack_n)
  );

  dramc_addr_mux #(.COL_W(COL_W)) u_amux (
    .clk(clk), .rst_n(rst_n), .addr(addr), .row_sel(row_sel), .dram_a(dram_a)
  );
endmodule

// File: tb/sim_dram_ctrl.sv
`timescale 1ns/1ps
module sim_dram_ctrl;
  localparam int C = 9;
  localparam int PERIOD = 128;

  logic clk = 1'b0, rst_n = 1'b0;
  logic as_n = 1'b1, uds_n = 1'b1, lds_n = 1'b1, rw = 1'b1, lock = 1'b0, wait_one = 1'b0;
  logic [2*C-1:0] addr = 18'h2B3C4;
  logic dtack_n, ras_n, cas_n, we_n;
  logic [C-1:0] dram_a;

  int n_chk = 0, n_err = 0, cyc = 0, last_rel = -100;

  always #2.5 clk = ~clk;
  always @(posedge clk) if (!rst_n) cyc <= 0; else cyc <= cyc + 1;

  dram_ctrl u0 (.clk(clk), .rst_n(rst_n), .as_n(as_n), .uds_n(uds_n), .lds_n(lds_n),
    .rw(rw), .lock(lock), .wait_one(wait_one), .addr(addr), .dtack_n(dtack_n),
    .dram_a(dram_a), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n));

  // fields: [19] wait state, [18] read, [17:0] address
  localparam logic [19:0] VEC [6] = '{
    {1'b0, 1'b1, 18'h1F0A5}, {1'b1, 1'b1, 18'h2A5C3}, {1'b0, 1'b0, 18'h00FFF},
    {1'b1, 1'b0, 18'h3FE01}, {1'b0, 1'b1, 18'h3FFFF}, {1'b1, 1'b0, 18'h00000}};

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  // release an access and check the closing edge
  task automatic release_bus();
    int t;
    @(negedge clk); as_n = 1'b1; uds_n = 1'b1; lds_n = 1'b1; lock = 1'b0; rw = 1'b1;
    t = -1;
    for (int i = 0; i < 8 && t < 0; i++) begin
      @(negedge clk);
      if (ras_n) t = cyc;
    end
    chk(t >= 0 && (t % 2) == 1, "R6 release phase", t % 2, 1);
    chk(cas_n && dtack_n, "R6 CAS and DTACK released with RAS", int'(cas_n), 1);
    last_rel = t;
  endtask

  // wait for the access CAS then its acknowledge; returns cycle of CAS
  task automatic run_access(input bit ws, input bit rdv, input logic [17:0] a, output int t_cas);
    int t_ras, t_ack;
    string rq;
    rq = ws ? "R3" : "R2";
    t_ras = -1; t_cas = -1; t_ack = -1;
    for (int i = 0; i < 400 && t_ack < 0; i++) begin
      @(negedge clk);
      if (t_ras < 0 && !ras_n && cas_n) begin
        t_ras = cyc;
        chk((cyc % 2) == int'(ws), {rq, " RAS phase"}, cyc % 2, int'(ws));
        chk(dram_a == a[17:9], "R4 row held at RAS", int'(dram_a), int'(a[17:9]));
        chk(t_ras - last_rel >= 6, "R12 precharge gap", t_ras - last_rel, 6);
      end else if (t_ras >= 0 && t_cas < 0 && !cas_n) begin
        t_cas = cyc;
        chk(t_cas - t_ras == (ws ? 3 : 1), {rq, " RAS to CAS"}, t_cas - t_ras, ws ? 3 : 1);
        chk(dram_a == a[8:0], "R4 column at CAS", int'(dram_a), int'(a[8:0]));
        chk(we_n == rdv, "R7 write enable level", int'(we_n), int'(rdv));
      end else if (t_cas >= 0 && !dtack_n) begin
        t_ack = cyc;
        chk(t_ack - t_cas == (ws ? 4 : 2), "R5 CAS to DTACK", t_ack - t_cas, ws ? 4 : 2);
      end
    end
    chk(t_ack >= 0, "R5 acknowledge seen", t_ack, 0);
  endtask

  task automatic start_access(input bit ws, input bit rdv, input bit lk, input logic [17:0] a);
    @(negedge clk);
    wait_one = ws; rw = rdv; lock = lk; addr = a; uds_n = 1'b0; lds_n = 1'b0; as_n = 1'b0;
  endtask

  task automatic rmw(input bit ws, input logic [17:0] a);
    int tc, t2, ta;
    start_access(ws, 1'b1, 1'b1, a);
    run_access(ws, 1'b1, a, tc);
    @(negedge clk); uds_n = 1'b1; lds_n = 1'b1;
    @(negedge clk);
    chk(cas_n && !ras_n && dtack_n, "R8 CAS drops, RAS held", int'(cas_n), 1);
    rw = 1'b0;
    @(negedge clk);
    chk(cas_n && !ras_n, "R8 CAS waits on byte strobes", int'(cas_n), 1);
    chk(!we_n, "R7 write enable before second CAS", int'(we_n), 0);
    @(negedge clk);
    chk(cas_n, "R8 CAS still waiting", int'(cas_n), 1);
    uds_n = 1'b0;
    @(negedge clk);
    t2 = cyc;
    chk(!cas_n && !ras_n, "R8 second CAS one clock after strobe", int'(cas_n), 0);
    chk(dram_a == a[8:0], "R8 column kept for write half", int'(dram_a), int'(a[8:0]));
    ta = -1;
    for (int i = 0; i < 10 && ta < 0; i++) begin
      @(negedge clk);
      if (!dtack_n) ta = cyc;
    end
    chk(ta - t2 == (ws ? 4 : 2), "R5 second acknowledge", ta - t2, ws ? 4 : 2);
    release_bus();
  endtask

  // waits for a refresh CAS edge (CAS low, RAS high); returns its cycle
  task automatic wait_refresh(output int t);
    bit prev;
    t = -1; prev = 1'b1;
    for (int i = 0; i < 600 && t < 0; i++) begin
      @(negedge clk);
      if (prev && !cas_n && ras_n) t = cyc;
      prev = cas_n;
    end
    chk(t >= 0, "R10 refresh occurs", t, 0);
  endtask

  initial begin
    #(5.0 * 150000);
    n_err++;
    $display("FAIL watchdog: actual 1 expected 0");
    finish_run();
  end

  initial begin
    int tc, t0, t1, t2, tr;
    bit ok;
    // reset state
    repeat (3) @(negedge clk);
    chk(ras_n && cas_n && we_n && dtack_n, "R1 strobes negated in reset", int'(ras_n & cas_n & we_n & dtack_n), 1);
    chk(dram_a == '0, "R1 address zero in reset", int'(dram_a), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(dram_a == addr[17:9], "R1 row presented when idle", int'(dram_a), int'(addr[17:9]));
    chk(ras_n && cas_n && we_n && dtack_n, "R1 idle after release", 0, 1);

    // vector table
    for (int v = 0; v < 6; v++) begin
      start_access(VEC[v][19], VEC[v][18], 1'b0, VEC[v][17:0]);
      run_access(VEC[v][19], VEC[v][18], VEC[v][17:0], tc);
      release_bus();
    end

    // locked read-modify-write, both wait settings
    rmw(1'b0, 18'h15A5A);
    rmw(1'b1, 18'h2A5A5);

    // refresh shape and interval on an idle bus
    wait_refresh(t0);
    wait_refresh(t1);
    chk((t1 % 2) == 1, "R9 refresh CAS on falling phase", t1 % 2, 1);
    wait_refresh(t2);
    chk(t2 - t1 == PERIOD, "R10 refresh interval", t2 - t1, PERIOD);
    @(negedge clk);
    chk(!ras_n && !cas_n && we_n, "R9 RAS follows CAS", int'(ras_n), 0);
    tr = 1;
    while (!ras_n && tr < 20) begin @(negedge clk); if (!ras_n) tr++; end
    chk(tr == 3, "R9 refresh RAS width", tr, 3);
    chk(ras_n && cas_n && (cyc % 2) == 1, "R9 refresh release", cyc % 2, 1);
    last_rel = cyc;

    // write arriving during a refresh
    wait_refresh(t0);
    wait_one = 1'b0; rw = 1'b0; lock = 1'b0; addr = 18'h0A0F3;
    uds_n = 1'b0; lds_n = 1'b0; as_n = 1'b0;
    ok = 1'b1;
    for (int i = 0; i < 10 && !(ras_n && cas_n); i++) begin
      @(negedge clk);
      if (!we_n || !dtack_n) ok = 1'b0;
    end
    chk(ok, "R11 access held off during refresh", int'(ok), 1);
    last_rel = cyc;
    run_access(1'b0, 1'b0, 18'h0A0F3, tc);
    // hold the access well past a refresh interval
    ok = 1'b1;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (ras_n || cas_n) ok = 1'b0;
    end
    chk(ok, "R11 held access not interrupted", int'(ok), 1);
    release_bus();
    wait_refresh(t0);
    chk(t0 - last_rel <= 12, "R11 deferred refresh runs after release", t0 - last_rel, 12);

    // back-to-back accesses for the precharge gap
    @(negedge clk);
    last_rel = cyc;
    start_access(1'b0, 1'b1, 1'b0, 18'h12345);
    run_access(1'b0, 1'b1, 18'h12345, tc);
    release_bus();
    start_access(1'b0, 1'b0, 1'b0, 18'h0F0F0);
    run_access(1'b0, 1'b0, 18'h0F0F0, tc);
    release_bus();

    finish_run();
  end
endmodule